// File: doc/BRIEF.md
# Parallel Port FIFO with Burst-Limited DMA Request

This block is the data buffer of an extended-capability parallel port together with the logic that asks a host DMA engine for service. A byte FIFO sits between the host bus and the peripheral side of the port and runs in one direction at a time. When bytes flow toward the host, the peripheral side fills the FIFO and the host DMA engine drains it. When bytes flow toward the peripheral, the host fills the FIFO and the peripheral side drains it. The request line is registered. It updates on the same clock edge as the FIFO fill level, so it never lags the FIFO state by a cycle.

Two control bits gate the request: a DMA enable bit and a service bit. A terminal-count pulse that arrives while the acknowledge is active sets the service bit. The service bit drives the interrupt output and blocks further requests until software writes it back to zero. Each request burst is limited to a fixed number of acknowledged strobes. After the limit is reached, the request stays low until the acknowledge has been idle for a guard time. That guard time is given in nanoseconds and converted to whole clock cycles, rounded up.

During DMA, a host access is selected only by the active-low acknowledge together with a read or write strobe. No address is decoded.

Top module: `ppfifo_dma_req`

## Requirements
- R1: From reset, and on every clock edge while `fifo_mode` is 0, the FIFO is empty (`fill_count` = 0), `err_flag` is cleared and all pushes and pops are ignored.
- R2: The 4-bit `thr_field` encodes a service threshold equal to the field plus one, so the threshold runs from 1 to 16 entries.
- R3: `dreq` is 1 only while the DMA enable bit is 1 and the service bit is 0.
- R4: With `dir_to_host` = 1, `dreq` rises on the same edge at which `fill_count` becomes nonzero, provided DMA is allowed and no burst gap is running.
- R5: With `dir_to_host` = 1, `dreq` falls on the edge at which the FIFO becomes empty, and on any edge where `tc` = 1 while `dack_n` = 0.
- R6: With `dir_to_host` = 0, `dreq` is 1 while the number of free entries (16 − `fill_count`) is at least the threshold. It falls when the FIFO fills up or on terminal count.
- R7: A strobe is a cycle with `dack_n` = 0 and `host_rd` or `host_wr` = 1. On the edge of the 32nd strobe within one request, `dreq` falls. It stays low until `dack_n` has been 1 for GAP consecutive cycles, where GAP = ceil(350 ns / clock period), which is 18 at 20 ns. It may rise again on the following edge. The strobe count restarts whenever `dreq` falls.
- R8: `tc` = 1 with `dack_n` = 0 sets the service bit on that edge and takes precedence over a control write in the same cycle. `intr` shows the service bit.
- R9: The FIFO keeps byte order, and `rd_data` always shows the oldest byte. The host pops with `host_rd` (toward the host) and pushes with `host_wr` (toward the FIFO), and only while `dack_n` = 0. The peripheral side uses `per_wr` (toward the host) and `per_rd` (toward the FIFO).
- R10: A pop from an empty FIFO or a push into a full FIFO is ignored and sets `err_flag`. The flag stays set until reset or until `fifo_mode` is 0.
- R11: `ctl_we` = 1 loads `ctl_dma_en` into the DMA enable bit and `ctl_svc` into the service bit. Both bits reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = a FIFO-using port mode is selected |
| dir_to_host | input | 1 | 1 = FIFO drains to host, 0 = host fills FIFO |
| thr_field | input | 4 | Service threshold minus one |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_dma_en | input | 1 | DMA enable value to write |
| ctl_svc | input | 1 | Service bit value to write |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc | input | 1 | Terminal count from the DMA engine |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| per_wr | input | 1 | Peripheral-side push strobe |
| per_wdata | input | 8 | Peripheral-side push byte |
| per_rd | input | 1 | Peripheral-side pop strobe |
| rd_data | output | 8 | Oldest byte in the FIFO |
| dreq | output | 1 | DMA request |
| intr | output | 1 | Port interrupt (service bit) |
| fill_count | output | 5 | Number of stored bytes |
| err_flag | output | 1 | Sticky underflow/overflow flag |

## Verification
Each fault in the internal state reaches the ports within one clock edge:
- A wrong FIFO pointer shows up as a byte out of order on `rd_data` at the next pop.
- A miscounted fill level moves the edge at which `dreq` rises or falls.
- A burst counter that is off by one moves the fall of `dreq` away from the 32nd strobe.
- A wrong guard-time count changes how many idle cycles pass before `dreq` returns, which is 19 observed edges at the default settings.
- A service bit that is not latched leaves `intr` low and `dreq` high on the edge after terminal count.

The bench compares every output against a behavioural model on every cycle, so any of these faults is reported in the cycle in which it first appears.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

   typedef enum logic [1:0] {
      RQ_IDLE = 2'd0,
      RQ_ON   = 2'd1,
      RQ_GAP  = 2'd2
   } ppf_rq_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic                         pop,
   input  logic [DW-1:0]                wdata,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic [$clog2(DEPTH+1)-1:0]   cnt_nxt,
   output logic                         err
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ppf_store: DEPTH must be at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_inc, rp_inc;
   logic          do_push, do_pop, err_nxt;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise.
   generate
      if (DEPTH == (1 << AW)) begin : g_wrap_pow2
         assign wp_inc = wp + AW'(1);
         assign rp_inc = rp + AW'(1);
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
         assign rp_inc = (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
      end
   endgenerate

   assign do_push = push && !flush && (count != CW'(DEPTH));
   assign do_pop  = pop  && !flush && (count != '0);
   assign err_nxt = flush ? 1'b0
                  : (err || (push && !do_push) || (pop && !do_pop));

   always_comb begin
      if (flush) begin
         cnt_nxt = '0;
      end else begin
         unique case ({do_push, do_pop})
            2'b10:   cnt_nxt = count + CW'(1);
            2'b01:   cnt_nxt = count - CW'(1);
            default: cnt_nxt = count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
         err   <= 1'b0;
      end else begin
         count <= cnt_nxt;
         err   <= err_nxt;
         if (flush) begin
            wp <= '0;
            rp <= '0;
         end else begin
            if (do_push) wp <= wp_inc;
            if (do_pop)  rp <= rp_inc;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   assign head = mem[rp];

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !flush) |=> err);
   a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && !err));
   a_r10_full_push_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH) && push && !pop && !flush) |=> (count == CW'(DEPTH) && err));

endmodule

// File: rtl/ppf_ctlreg.sv
module ppf_ctlreg (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_we,
   input  logic ctl_dma_en,
   input  logic ctl_svc,
   input  logic tc_hit,
   output logic dma_en,
   output logic svc,
   output logic dma_nxt,
   output logic svc_nxt
);
   assign dma_nxt = ctl_we ? ctl_dma_en : dma_en;
   assign svc_nxt = tc_hit ? 1'b1 : (ctl_we ? ctl_svc : svc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_en <= 1'b0;
         svc    <= 1'b0;
      end else begin
         dma_en <= dma_nxt;
         svc    <= svc_nxt;
      end
   end

   a_r8_tc_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
      tc_hit |=> svc);
   a_r11_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !tc_hit) |=> (dma_en == $past(ctl_dma_en) && svc == $past(ctl_svc)));

endmodule

// File: rtl/ppf_reqfsm.sv
module ppf_reqfsm
   import ppf_pkg::*;
#(
   parameter int BURST_MAX = 32,
   parameter int GAP_CYC   = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic strobe,
   input  logic dack_n,
   output logic dreq
);
   localparam int BW = $clog2(BURST_MAX + 1);
   localparam int GW = $clog2(GAP_CYC + 1);

   generate
      if (BURST_MAX < 1) begin : g_bad_burst
         $error("ppf_reqfsm: BURST_MAX must be at least 1");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("ppf_reqfsm: GAP_CYC must be at least 1");
      end
   endgenerate

   ppf_rq_e       st;
   logic [BW-1:0] bcnt;
   logic [GW-1:0] icnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RQ_IDLE;
         bcnt <= '0;
         icnt <= '0;
      end else begin
         unique case (st)
            RQ_IDLE: begin
               bcnt <= '0;
               icnt <= '0;
               if (want) st <= RQ_ON;
            end
            RQ_ON: begin
               if (strobe && bcnt == BW'(BURST_MAX-1)) begin
                  st   <= RQ_GAP;
                  bcnt <= '0;
                  icnt <= '0;
               end else if (!want) begin
                  st   <= RQ_IDLE;
                  bcnt <= '0;
               end else if (strobe) begin
                  bcnt <= bcnt + BW'(1);
               end
            end
            RQ_GAP: begin
               if (!dack_n) begin
                  icnt <= '0;
               end else if (icnt == GW'(GAP_CYC-1)) begin
                  st   <= RQ_IDLE;
                  icnt <= '0;
               end else begin
                  icnt <= icnt + GW'(1);
               end
            end
            default: st <= RQ_IDLE;
         endcase
      end
   end

   assign dreq = (st == RQ_ON);

   a_r7_gap_needs_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RQ_GAP && !dack_n) |=> (st == RQ_GAP));
   a_r7_gap_no_direct_req: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RQ_GAP) |=> !dreq);
   a_r3_drop_without_want: assert property (@(posedge clk) disable iff (!rst_n)
      !want |=> !dreq);

endmodule

// File: rtl/ppfifo_dma_req.sv
module ppfifo_dma_req
   import ppf_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int DW        = 8,
   parameter int BURST_MAX = 32,
   parameter int CLK_NS    = 20,
   parameter int GAP_NS    = 350
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fifo_mode,
   input  logic                         dir_to_host,
   input  logic [$clog2(DEPTH)-1:0]     thr_field,
   input  logic                         ctl_we,
   input  logic                         ctl_dma_en,
   input  logic                         ctl_svc,
   input  logic                         dack_n,
   input  logic                         tc,
   input  logic                         host_rd,
   input  logic                         host_wr,
   input  logic [DW-1:0]                host_wdata,
   input  logic                         per_wr,
   input  logic [DW-1:0]                per_wdata,
   input  logic                         per_rd,
   output logic [DW-1:0]                rd_data,
   output logic                         dreq,
   output logic                         intr,
   output logic [$clog2(DEPTH+1)-1:0]   fill_count,
   output logic                         err_flag
);
   localparam int TW      = $clog2(DEPTH);
   localparam int CW      = $clog2(DEPTH+1);
   localparam int GAP_CYC = ceil_div(GAP_NS, CLK_NS);
   localparam int KW      = $clog2(BURST_MAX + 2);

   generate
      if ((1 << TW) != DEPTH) begin : g_bad_depth
         $error("ppfifo_dma_req: DEPTH must be a power of two");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("ppfifo_dma_req: CLK_NS must be positive");
      end
   endgenerate

   logic          strobe, tc_hit, push, pop, want;
   logic [DW-1:0] wdata;
   logic [CW-1:0] cnt_nxt, free_nxt, thr;
   logic          dma_en, svc, dma_nxt, svc_nxt;

   assign strobe = !dack_n && (host_rd || host_wr);
   assign tc_hit = !dack_n && tc;

   assign push  = fifo_mode && (dir_to_host ? per_wr : (host_wr && !dack_n));
   assign pop   = fifo_mode && (dir_to_host ? (host_rd && !dack_n) : per_rd);
   assign wdata = dir_to_host ? per_wdata : host_wdata;

   ppf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (!fifo_mode),
      .push    (push),
      .pop     (pop),
      .wdata   (wdata),
      .head    (rd_data),
      .count   (fill_count),
      .cnt_nxt (cnt_nxt),
      .err     (err_flag)
   );

   ppf_ctlreg u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (ctl_we),
      .ctl_dma_en (ctl_dma_en),
      .ctl_svc    (ctl_svc),
      .tc_hit     (tc_hit),
      .dma_en     (dma_en),
      .svc        (svc),
      .dma_nxt    (dma_nxt),
      .svc_nxt    (svc_nxt)
   );

   assign thr      = CW'(thr_field) + CW'(1);
   assign free_nxt = CW'(DEPTH) - cnt_nxt;
   assign want     = fifo_mode && dma_nxt && !svc_nxt &&
                     (dir_to_host ? (cnt_nxt != '0) : (free_nxt >= thr));

   ppf_reqfsm #(.BURST_MAX(BURST_MAX), .GAP_CYC(GAP_CYC)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .want   (want),
      .strobe (strobe),
      .dack_n (dack_n),
      .dreq   (dreq)
   );

   assign intr = svc;

   // Strobes seen during one continuous request, for the burst-cap check.
   logic [KW-1:0] burst_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      burst_seen <= '0;
      else if (!dreq)  burst_seen <= '0;
      else if (strobe) burst_seen <= burst_seen + KW'(1);
   end

   a_r7_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      burst_seen <= KW'(BURST_MAX));
   a_r3_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      dreq |-> (dma_en && !svc));
   a_r4_req_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && dir_to_host && $stable(dir_to_host)) |-> (fill_count != '0));
   a_r6_req_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dir_to_host && $stable(dir_to_host) && $stable(thr_field))
      |-> ((CW'(DEPTH) - fill_count) >= thr));
   a_r5_tc_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
      tc_hit |=> (!dreq && intr));

endmodule

// File: tb/ppfifo_dma_req_test.sv
module ppfifo_dma_req_test;
   localparam int CLK_NS = 20;
   localparam int GAPC   = (350 + CLK_NS - 1) / CLK_NS;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fifo_mode, dir_to_host, ctl_we, ctl_dma_en, ctl_svc;
   logic [3:0] thr_field;
   logic       dack_n, tc, host_rd, host_wr, per_wr, per_rd;
   logic [7:0] host_wdata, per_wdata;
   logic [7:0] rd_data;
   logic       dreq, intr, err_flag;
   logic [4:0] fill_count;

   int total = 0;
   int bad   = 0;

   always #(CLK_NS/2) clk = ~clk;

   ppfifo_dma_req uut (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .dir_to_host(dir_to_host),
      .thr_field(thr_field), .ctl_we(ctl_we), .ctl_dma_en(ctl_dma_en), .ctl_svc(ctl_svc),
      .dack_n(dack_n), .tc(tc), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .per_wr(per_wr), .per_wdata(per_wdata), .per_rd(per_rd),
      .rd_data(rd_data), .dreq(dreq), .intr(intr), .fill_count(fill_count),
      .err_flag(err_flag)
   );

   // Behavioural model of the requirements
   logic [7:0] m_mem [16];
   int m_cnt = 0, m_hd = 0, m_tl = 0;
   int m_st = 0, m_burst = 0, m_idle = 0;
   bit m_dma = 0, m_svc = 0, m_err = 0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit strobe, tch, push, pop, pok, qok, want;
      logic [7:0] wd;
      strobe = !dack_n && (host_rd || host_wr);
      tch    = !dack_n && tc;
      push   = fifo_mode && (dir_to_host ? per_wr : (host_wr && !dack_n));
      pop    = fifo_mode && (dir_to_host ? (host_rd && !dack_n) : per_rd);
      wd     = dir_to_host ? per_wdata : host_wdata;
      if (!fifo_mode) begin
         m_cnt = 0; m_hd = 0; m_tl = 0; m_err = 0;
      end else begin
         pok = push && (m_cnt < 16);
         qok = pop && (m_cnt > 0);
         if ((push && !pok) || (pop && !qok)) m_err = 1;
         if (pok) begin m_mem[m_tl] = wd; m_tl = (m_tl + 1) % 16; end
         if (qok) m_hd = (m_hd + 1) % 16;
         m_cnt = m_cnt + int'(pok) - int'(qok);
      end
      if (tch) m_svc = 1;
      else if (ctl_we) m_svc = ctl_svc;
      if (ctl_we) m_dma = ctl_dma_en;
      want = fifo_mode && m_dma && !m_svc &&
             (dir_to_host ? (m_cnt >= 1) : ((16 - m_cnt) >= int'(thr_field) + 1));
      case (m_st)
         0: begin m_burst = 0; m_idle = 0; if (want) m_st = 1; end
         1: begin
            if (strobe && m_burst == 31) begin m_st = 2; m_burst = 0; m_idle = 0; end
            else if (!want) begin m_st = 0; m_burst = 0; end
            else if (strobe) m_burst++;
         end
         default: begin
            if (dack_n == 1'b0) m_idle = 0;
            else if (m_idle == GAPC - 1) begin m_st = 0; m_idle = 0; end
            else m_idle++;
         end
      endcase
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      #2;
      chk("R5 dreq vs model", int'(dreq), int'(m_st == 1));
      chk("R9 fill_count vs model", int'(fill_count), m_cnt);
      chk("R8 intr vs model", int'(intr), int'(m_svc));
      chk("R10 err_flag vs model", int'(err_flag), int'(m_err));
      if (m_cnt > 0) chk("R9 rd_data vs model", int'(rd_data), int'(m_mem[m_hd]));
   endtask

   task automatic quiet();
      ctl_we = 0; dack_n = 1; tc = 0; host_rd = 0; host_wr = 0;
      per_wr = 0; per_rd = 0;
   endtask

   task automatic ctl(input bit d, input bit s);
      ctl_we = 1; ctl_dma_en = d; ctl_svc = s;
      cyc();
      ctl_we = 0;
   endtask

   initial begin
      #(CLK_NS * 200000);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      rst_n = 0; fifo_mode = 0; dir_to_host = 1; thr_field = 0;
      ctl_dma_en = 0; ctl_svc = 0; host_wdata = 0; per_wdata = 0;
      quiet();
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      chk("R1 reset fill_count", int'(fill_count), 0);
      chk("R1 reset dreq", int'(dreq), 0);
      chk("R1 reset intr", int'(intr), 0);
      chk("R1 reset err", int'(err_flag), 0);

      // R1: pushes ignored while fifo disabled
      per_wr = 1; per_wdata = 8'hAA;
      repeat (3) cyc();
      chk("R1 disabled push ignored", int'(fill_count), 0);
      quiet();

      // R3: data present but DMA disabled
      fifo_mode = 1;
      per_wr = 1; per_wdata = 8'h11; cyc();
      per_wdata = 8'h22; cyc();
      quiet(); cyc();
      chk("R3 no req without enable", int'(dreq), 0);
      ctl(1, 0);
      chk("R11 enable write raises req", int'(dreq), 1);
      chk("R9 head is first byte", int'(rd_data), 8'h11);

      // R5: drain to empty
      host_rd = 1; dack_n = 0; cyc();
      chk("R9 second byte at head", int'(rd_data), 8'h22);
      cyc();
      chk("R5 req drops on empty", int'(dreq), 0);
      quiet(); cyc();

      // R4: first byte raises request on same edge
      per_wr = 1; per_wdata = 8'h33; cyc();
      chk("R4 req with first byte", int'(dreq), 1);
      per_wdata = 8'h44; cyc();
      per_wdata = 8'h55; cyc();
      quiet();

      // R8: terminal count with acknowledge
      host_rd = 1; dack_n = 0; tc = 1; cyc();
      chk("R8 intr after tc", int'(intr), 1);
      chk("R8 req dropped after tc", int'(dreq), 0);
      quiet(); cyc();
      chk("R8 service holds req off", int'(dreq), 0);
      ctl_we = 1; ctl_dma_en = 1; ctl_svc = 0; dack_n = 0; tc = 1; cyc();
      chk("R8 tc wins over write", int'(intr), 1);
      quiet();
      ctl(1, 0);
      chk("R11 clearing service restores req", int'(dreq), 1);

      // R7: burst limit and idle gap
      for (int k = 1; k <= 32; k++) begin
         per_wr = 1; per_wdata = 8'(k); host_rd = 1; dack_n = 0;
         cyc();
         if (k < 32) chk("R7 req held inside burst", int'(dreq), 1);
         else        chk("R7 req drops after 32nd strobe", int'(dreq), 0);
      end
      quiet();
      dack_n = 0; repeat (5) cyc();
      chk("R7 req held low while ack active", int'(dreq), 0);
      dack_n = 1;
      n = 0;
      while (!dreq && n < 60) begin cyc(); n++; end
      chk("R7 idle edges before req returns", n, GAPC + 1);

      // R6 / R2: host fills FIFO, threshold 4
      fifo_mode = 0; cyc();
      chk("R1 flush empties", int'(fill_count), 0);
      fifo_mode = 1; dir_to_host = 0; thr_field = 4'd3; cyc();
      chk("R6 req with free room", int'(dreq), 1);
      for (int i = 1; i <= 13; i++) begin
         host_wr = 1; dack_n = 0; host_wdata = 8'(i + 8'h60);
         cyc();
         if (i == 12) chk("R2 req at free equal threshold", int'(dreq), 1);
         if (i == 13) chk("R2 req drops below threshold", int'(dreq), 0);
      end
      for (int i = 14; i <= 17; i++) begin
         host_wr = 1; dack_n = 0; host_wdata = 8'(i + 8'h60);
         cyc();
      end
      chk("R10 full push ignored", int'(fill_count), 16);
      chk("R10 full push flags error", int'(err_flag), 1);
      quiet();
      thr_field = 4'd15;
      for (int i = 1; i <= 16; i++) begin
         chk("R9 order toward peripheral", int'(rd_data), i + 8'h60);
         per_rd = 1; cyc();
         if (i < 16) chk("R6 no req until fully free", int'(dreq), 0);
      end
      chk("R6 req when threshold 16 met", int'(dreq), 1);
      quiet(); cyc();

      // R10: pop on empty toward host, then clear by disabling
      fifo_mode = 0; cyc();
      chk("R1 error cleared by disable", int'(err_flag), 0);
      fifo_mode = 1; dir_to_host = 1; cyc();
      host_rd = 1; dack_n = 0; cyc();
      chk("R10 empty pop flags error", int'(err_flag), 1);
      chk("R10 empty pop leaves count", int'(fill_count), 0);
      quiet(); cyc();
      // R3: disabling DMA drops request
      per_wr = 1; per_wdata = 8'h77; cyc(); quiet();
      ctl(0, 0);
      chk("R3 req drops when disabled", int'(dreq), 0);
      ctl(1, 0);

      // Constrained random phase
      for (int i = 0; i < 6000; i++) begin
         quiet();
         if ($urandom_range(0, 299) == 0) fifo_mode = ~fifo_mode;
         if ($urandom_range(0, 199) == 0) dir_to_host = ~dir_to_host;
         if ($urandom_range(0, 99) == 0) thr_field = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 39) == 0) begin
            ctl_we = 1; ctl_dma_en = ($urandom_range(0, 7) != 0);
            ctl_svc = ($urandom_range(0, 5) == 0);
         end
         dack_n = ($urandom_range(0, 2) == 0);
         tc = ($urandom_range(0, 63) == 0);
         host_rd = $urandom_range(0, 1); host_wr = $urandom_range(0, 1);
         per_wr = $urandom_range(0, 1);  per_rd = $urandom_range(0, 1);
         host_wdata = 8'($urandom); per_wdata = 8'($urandom);
         cyc();
      end
      quiet();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule